// File: doc/BRIEF.md
# Multiplexed Bus Machine-Cycle Sequencer

This block produces the external bus timing for a small 8-bit processor whose low address byte and data byte share one set of pins. The core raises a request that carries a cycle kind, a 16-bit address and a write byte. The block then steps through its T-states and drives the following:

- the upper address pins;
- the shared address/data pins, together with their drive enable;
- the latch strobe, the memory/I-O select and the two status bits;
- the active-low read and write strobes.

Read data is taken from the shared pins at the end of the third T-state. It is returned with a one-cycle done pulse.

The block supports five cycle kinds. Four of them last three T-states. An opcode fetch adds a fourth T-state in which no strobe is active and the pins are not driven, so that the core can decode. A new request is taken only while the sequencer is idle. The bus is modelled as a drive-enable output plus a separate input sampled from the pins.

Top module: `bus_cycle_seq`

## Requirements
- R1: While rst_ni is low and after reset, the sequencer is idle with these outputs: ale_o=0, rd_n_o=1, wr_n_o=1, ad_oe_o=0, busy_o=0, done_o=0, io_m_o=0, s1_o=0, s0_o=0, rdata_o=0.
- R2: The first T-state begins one clock after an accepted request. During the first T-state:
  - ale_o is 1;
  - ad_oe_o is 1;
  - ad_o carries addr_i[7:0];
  - a_hi_o carries addr_i[15:8] for memory kinds.
  ale_o is 0 in every other cycle.
- R3: kind_i encodes the cycle kind: 0 opcode fetch, 1 memory read, 2 memory write, 3 I/O read, 4 I/O write. {io_m_o,s1_o,s0_o} takes these values from the first T-state to the last:

  | Kind | {io_m_o,s1_o,s0_o} |
  |---|---|
  | opcode fetch | 011 |
  | memory read | 010 |
  | memory write | 001 |
  | I/O read | 110 |
  | I/O write | 101 |

  The value is 000 when idle.
- R4: For kinds 0, 1 and 3:
  - rd_n_o is 0 in the second and third T-states and 1 otherwise;
  - ad_oe_o is 0 whenever rd_n_o is 0.
- R5: For kinds 2 and 4:
  - wr_n_o is 0 in the second and third T-states;
  - ad_o carries wdata_i with ad_oe_o=1 in those two T-states;
  - ad_oe_o is 0 after the third T-state.
- R6: An opcode fetch holds busy_o high for 4 cycles, and its fourth T-state has rd_n_o=1, wr_n_o=1, ad_oe_o=0. All other kinds hold busy_o high for 3 cycles.
- R7: At the edge that ends the third T-state, the block does the following:
  - for read kinds, it loads ad_i into rdata_o;
  - for every kind, it raises done_o for exactly one cycle.
  Write kinds leave rdata_o unchanged.
- R8: For kinds 3 and 4, the port address addr_i[7:0] appears on a_hi_o as well as on ad_o in the first T-state.
- R9: A request made while busy_o is 1 has no effect. A request with kind_i of 5, 6 or 7 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request a bus cycle |
| kind_i | input | 3 | Cycle kind |
| addr_i | input | 16 | Memory address or port number |
| wdata_i | input | 8 | Write byte |
| ad_i | input | 8 | Value seen on shared pins |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Captured read byte |
| a_hi_o | output | 8 | Upper address pins |
| ad_o | output | 8 | Shared address/data pins, output value |
| ad_oe_o | output | 1 | Drive enable for shared pins |
| ale_o | output | 1 | Address latch strobe |
| io_m_o | output | 1 | 1 for I/O, 0 for memory |
| s1_o | output | 1 | Status bit 1 |
| s0_o | output | 1 | Status bit 0 |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |

## Verification
The request is applied before clock edge k. The latch strobe and address therefore appear in the cycle after edge k, and the strobes of T2 and T3 appear after edges k+1 and k+2. The done pulse and the captured read byte appear after edge k+3. For a fetch, busy falls after edge k+4. The bench drives and samples only on falling edges. It checks each T-state in the half-cycle that follows the rising edge that entered it. Each step samples once, so every expected value is tied to one known count of registers from the request.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

  typedef enum logic [2:0] {
    CK_OPF  = 3'd0,
    CK_MRD  = 3'd1,
    CK_MWR  = 3'd2,
    CK_IORD = 3'd3,
    CK_IOWR = 3'd4
  } cyc_kind_e;

  typedef enum logic [2:0] {
    TS_IDLE,
    TS_T1,
    TS_T2,
    TS_T3,
    TS_T4
  } tstate_e;

  function automatic logic kind_ok(logic [2:0] k);
    return k <= 3'd4;
  endfunction

  function automatic logic kind_rd(cyc_kind_e k);
    return (k == CK_OPF) || (k == CK_MRD) || (k == CK_IORD);
  endfunction

  function automatic logic kind_io(cyc_kind_e k);
    return (k == CK_IORD) || (k == CK_IOWR);
  endfunction

  // {io_m, s1, s0}
  function automatic logic [2:0] kind_status(cyc_kind_e k);
    case (k)
      CK_OPF:  return 3'b011;
      CK_MRD:  return 3'b010;
      CK_MWR:  return 3'b001;
      CK_IORD: return 3'b110;
      CK_IOWR: return 3'b101;
      default: return 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/bus_tstate_fsm.sv
module bus_tstate_fsm
  import bus_seq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  input  logic    fetch_i,
  output tstate_e state_o
);

  tstate_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      TS_IDLE: if (start_i) state_d = TS_T1;
      TS_T1:   state_d = TS_T2;
      TS_T2:   state_d = TS_T3;
      TS_T3:   state_d = fetch_i ? TS_T4 : TS_IDLE;
      TS_T4:   state_d = TS_IDLE;
      default: state_d = TS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= TS_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

endmodule

// File: rtl/bus_pin_drive.sv
module bus_pin_drive
  import bus_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  tstate_e             state_i,
  input  cyc_kind_e           kind_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic                busy_o,
  output logic [DATA_W-1:0]   a_hi_o,
  output logic [DATA_W-1:0]   ad_o,
  output logic                ad_oe_o,
  output logic                ale_o,
  output logic                io_m_o,
  output logic                s1_o,
  output logic                s0_o,
  output logic                rd_n_o,
  output logic                wr_n_o
);

  logic rd_kind, io_kind;
  assign rd_kind = kind_rd(kind_i);
  assign io_kind = kind_io(kind_i);

  always_comb begin
    busy_o                = (state_i != TS_IDLE);
    a_hi_o                = '0;
    ad_o                  = '0;
    ad_oe_o               = 1'b0;
    ale_o                 = 1'b0;
    {io_m_o, s1_o, s0_o}  = 3'b000;
    rd_n_o                = 1'b1;
    wr_n_o                = 1'b1;
    if (busy_o) begin
      // port number mirrored onto the upper pins for I/O kinds
      a_hi_o               = io_kind ? addr_i[DATA_W-1:0] : addr_i[ADDR_W-1:DATA_W];
      {io_m_o, s1_o, s0_o} = kind_status(kind_i);
    end
    case (state_i)
      TS_T1: begin
        ale_o   = 1'b1;
        ad_o    = addr_i[DATA_W-1:0];
        ad_oe_o = 1'b1;
      end
      TS_T2, TS_T3: begin
        if (rd_kind) begin
          rd_n_o = 1'b0;
        end else begin
          wr_n_o  = 1'b0;
          ad_o    = wdata_i;
          ad_oe_o = 1'b1;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/bus_rd_capture.sv
module bus_rd_capture
  import bus_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  tstate_e           state_i,
  input  logic              rd_kind_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= (state_i == TS_T3);
      if (state_i == TS_T3 && rd_kind_i) rdata_o <= ad_i;
    end
  end

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bus_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [2:0]        kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] a_hi_o,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic              ale_o,
  output logic              io_m_o,
  output logic              s1_o,
  output logic              s0_o,
  output logic              rd_n_o,
  output logic              wr_n_o
);

  tstate_e           state;
  cyc_kind_e         kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              start;

  assign start = req_i && (state == TS_IDLE) && kind_ok(kind_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q  <= CK_OPF;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (start) begin
      kind_q  <= cyc_kind_e'(kind_i);
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  bus_tstate_fsm i_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .fetch_i (kind_q == CK_OPF),
    .state_o (state)
  );

  bus_pin_drive #(.DATA_W(DATA_W)) i_drive (
    .state_i (state),
    .kind_i  (kind_q),
    .addr_i  (addr_q),
    .wdata_i (wdata_q),
    .busy_o  (busy_o),
    .a_hi_o  (a_hi_o),
    .ad_o    (ad_o),
    .ad_oe_o (ad_oe_o),
    .ale_o   (ale_o),
    .io_m_o  (io_m_o),
    .s1_o    (s1_o),
    .s0_o    (s0_o),
    .rd_n_o  (rd_n_o),
    .wr_n_o  (wr_n_o)
  );

  bus_rd_capture #(.DATA_W(DATA_W)) i_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_i   (state),
    .rd_kind_i (kind_rd(kind_q)),
    .ad_i      (ad_i),
    .rdata_o   (rdata_o),
    .done_o    (done_o)
  );

endmodule

// File: rtl/bus_cycle_seq_chk.sv
module bus_cycle_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_o,
  input logic done_o,
  input logic ale_o,
  input logic ad_oe_o,
  input logic io_m_o,
  input logic s1_o,
  input logic s0_o,
  input logic rd_n_o,
  input logic wr_n_o
);

  assert_ale_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o);

  assert_ale_at_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ale_o);

  assert_status_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !ale_o) |-> $stable({io_m_o, s1_o, s0_o}));

  assert_strobe_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_n_o && !wr_n_o));

  assert_rd_no_drive_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_n_o |-> !ad_oe_o);

  assert_rd_two_cycles_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_n_o) |=> !rd_n_o);

  assert_wr_two_cycles_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wr_n_o) |=> !wr_n_o);

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

endmodule

bind bus_cycle_seq bus_cycle_seq_chk i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .ale_o   (ale_o),
  .ad_oe_o (ad_oe_o),
  .io_m_o  (io_m_o),
  .s1_o    (s1_o),
  .s0_o    (s0_o),
  .rd_n_o  (rd_n_o),
  .wr_n_o  (wr_n_o)
);

// File: tb/test_bus_cycle_seq.sv
`timescale 1ns/1ps
module test_bus_cycle_seq;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_i = 1'b0;
  logic [2:0] kind_i = '0;
  logic [15:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] ad_i = '0;
  logic       busy_o, done_o, ad_oe_o, ale_o, io_m_o, s1_o, s0_o, rd_n_o, wr_n_o;
  logic [7:0] rdata_o, a_hi_o, ad_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] last_rd = 8'h00;

  always #10 clk_i = ~clk_i;

  bus_cycle_seq i_bus_cycle_seq (
    .clk_i, .rst_ni, .req_i, .kind_i, .addr_i, .wdata_i, .ad_i,
    .busy_o, .done_o, .rdata_o, .a_hi_o, .ad_o, .ad_oe_o, .ale_o,
    .io_m_o, .s1_o, .s0_o, .rd_n_o, .wr_n_o
  );

  // {kind, addr, wdata, byte on pins}
  localparam int NV = 7;
  localparam logic [34:0] VEC [NV] = '{
    {3'd0, 16'h2000, 8'h00, 8'h06},
    {3'd1, 16'h2001, 8'h00, 8'h43},
    {3'd3, 16'h41C0, 8'h00, 8'h5E},
    {3'd4, 16'h0007, 8'hC7, 8'h11},
    {3'd2, 16'h526A, 8'hC7, 8'h22},
    {3'd0, 16'h41FF, 8'h00, 8'h32},
    {3'd1, 16'hFFFF, 8'h00, 8'hA5}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_stat(input logic [2:0] k);
    case (k)
      3'd0: return 3'b011;
      3'd1: return 3'b010;
      3'd2: return 3'b001;
      3'd3: return 3'b110;
      3'd4: return 3'b101;
      default: return 3'b000;
    endcase
  endfunction

  // entered at a falling edge
  task automatic run_cycle(input logic [2:0] k, input logic [15:0] a,
                           input logic [7:0] wd, input logic [7:0] pin);
    logic rd, io;
    logic [7:0] hi;
    rd = (k == 3'd0) || (k == 3'd1) || (k == 3'd3);
    io = (k == 3'd3) || (k == 3'd4);
    hi = io ? a[7:0] : a[15:8];
    req_i = 1'b1; kind_i = k; addr_i = a; wdata_i = wd; ad_i = pin;
    @(negedge clk_i);
    req_i = 1'b0;
    chk("R2 ale T1", ale_o, 1);
    chk("R2 oe T1", ad_oe_o, 1);
    chk("R2 ad T1", ad_o, a[7:0]);
    chk(io ? "R8 a_hi port" : "R2 a_hi", a_hi_o, hi);
    chk("R3 status T1", {io_m_o, s1_o, s0_o}, exp_stat(k));
    chk("R4 rd_n T1", rd_n_o, 1);
    chk("R5 wr_n T1", wr_n_o, 1);
    for (int t = 2; t <= 3; t++) begin
      @(negedge clk_i);
      chk("R2 ale low", ale_o, 0);
      chk("R3 status hold", {io_m_o, s1_o, s0_o}, exp_stat(k));
      chk("R4 rd_n", rd_n_o, rd ? 0 : 1);
      chk("R5 wr_n", wr_n_o, rd ? 1 : 0);
      chk(rd ? "R4 oe" : "R5 oe", ad_oe_o, rd ? 0 : 1);
      if (!rd) chk("R5 wdata", ad_o, wd);
      chk("R6 busy", busy_o, 1);
    end
    @(negedge clk_i);
    chk("R7 done", done_o, 1);
    if (rd) last_rd = pin;
    chk("R7 rdata", rdata_o, last_rd);
    chk("R5 oe after", ad_oe_o, 0);
    if (k == 3'd0) begin
      chk("R6 fetch busy T4", busy_o, 1);
      chk("R6 T4 rd_n", rd_n_o, 1);
      chk("R6 T4 wr_n", wr_n_o, 1);
      chk("R2 T4 ale", ale_o, 0);
      @(negedge clk_i);
      chk("R7 done once", done_o, 0);
      chk("R6 fetch end", busy_o, 0);
    end else begin
      chk("R6 busy end", busy_o, 0);
    end
  endtask

  task automatic idle_chk(input string tag);
    chk({tag, " ale"}, ale_o, 0);
    chk({tag, " rd_n"}, rd_n_o, 1);
    chk({tag, " wr_n"}, wr_n_o, 1);
    chk({tag, " oe"}, ad_oe_o, 0);
    chk({tag, " busy"}, busy_o, 0);
    chk({tag, " status"}, {io_m_o, s1_o, s0_o}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    idle_chk("R1 in reset");
    chk("R1 done", done_o, 0);
    chk("R1 rdata", rdata_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    idle_chk("R1 after reset");

    for (int i = 0; i < NV; i++)
      run_cycle(VEC[i][34:32], VEC[i][31:16], VEC[i][15:8], VEC[i][7:0]);

    // R9: request while busy
    req_i = 1'b1; kind_i = 3'd1; addr_i = 16'h1234; ad_i = 8'h77;
    @(negedge clk_i);
    req_i = 1'b0;
    @(negedge clk_i);
    req_i = 1'b1; kind_i = 3'd2; wdata_i = 8'h99;
    @(negedge clk_i);
    req_i = 1'b0;
    chk("R9 no write strobe", wr_n_o, 1);
    @(negedge clk_i);
    last_rd = 8'h77;
    chk("R9 done", done_o, 1);
    chk("R9 rdata", rdata_o, 8'h77);
    chk("R9 busy after", busy_o, 0);
    @(negedge clk_i);
    chk("R9 no restart ale", ale_o, 0);
    chk("R9 no restart busy", busy_o, 0);

    // R9: undefined kinds
    for (int k = 5; k < 8; k++) begin
      req_i = 1'b1; kind_i = 3'(k);
      @(negedge clk_i);
      req_i = 1'b0;
      idle_chk("R9 bad kind");
    end

    // R7: write keeps rdata
    run_cycle(3'd2, 16'h8000, 8'h3C, 8'hEE);
    chk("R7 write keeps rdata", rdata_o, 8'h77);

    // R1: reset mid cycle
    req_i = 1'b1; kind_i = 3'd1; addr_i = 16'h0100;
    @(negedge clk_i);
    req_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    idle_chk("R1 mid reset");
    chk("R1 mid reset rdata", rdata_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    idle_chk("R1 post reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule